// File: doc/BRIEF.md
# Scanned Keyboard State Capture

This block rebuilds the pressed/released state of a 49-key keyboard from a single serial return line. A scan generator elsewhere steps through 64 time slots per scan cycle. For each slot it supplies a one-clock slot strobe, the slot number, an active-low end-of-cycle marker and a scan-cycle parity bit. The keyboard pulls the return line low during the slot of any key that is held down. The block decodes that line against the slot number and gathers one bit per key in a working register.

At the end-of-cycle marker the block may copy the working register to its outputs. It does so only when the parity bit equals a chosen value, so the outputs refresh on every second scan cycle. The outputs are the full key vector and the same vector cut into a lower half and an upper half, for split-keyboard use. A one-clock strobe marks every refresh. The working register is then emptied for the next cycle.

Top module: `keyscan_capture`

## Requirements
- R1: After reset, `keys`, `keys_lo` and `keys_hi` are all zero (all keys released) and `keys_valid` is 0.
- R2: A slot strobe with `slot_idx` = 8 + i (i from 0 to 48) and `key_n` low records key i as pressed (bit i = 1). `key_n` high records it as released (bit i = 0). The recorded value appears on `keys` at the next refresh.
- R3: Strobed slots with numbers below 8 or above 56 leave the key state unchanged, whatever the level of `key_n`.
- R4: A refresh happens only on a slot strobe with `sync_n` low and `scan_par` = 0. A strobe with `sync_n` low and `scan_par` = 1 leaves `keys` unchanged.
- R5: `keys_valid` is 1 for exactly the one clock that follows a refresh edge, and 0 at all other times.
- R6: Every strobed slot with `sync_n` low empties the working register, whatever the parity. A key slot that is not strobed in the next cycle therefore reads as released at the following refresh.
- R7: `keys_lo` carries keys 1 to 24 (bits 0 to 23 of `keys`). `keys_hi` carries keys 25 to 49 (bits 24 to 48 of `keys`).
- R8: `keys` holds its value in every clock in which no refresh happens.
- R9: While `slot_en` is 0, changes on `key_n`, `slot_idx`, `sync_n` and `scan_par` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_en | input | 1 | One-clock strobe per scan slot; inputs are sampled when it is high |
| slot_idx | input | 6 | Number of the current slot |
| sync_n | input | 1 | End-of-cycle marker, active low |
| scan_par | input | 1 | Scan-cycle parity |
| key_n | input | 1 | Serial key line, low = key of this slot pressed |
| keys | output | 49 | Published key vector, bit i = key i+1, 1 = pressed |
| keys_lo | output | 24 | Lower half of the published vector (keys 1-24) |
| keys_hi | output | 25 | Upper half of the published vector (keys 25-49) |
| keys_valid | output | 1 | One-clock strobe after each refresh |

## Verification
The bench builds the block with its default parameters: 49 keys starting at slot 8, a 24-key lower half, 6-bit slot numbers and a commit parity of 0. With these values the slot edges on both sides of the key window (7/8 and 56/57) and the split boundary between keys 24 and 25 can all be reached. Random key patterns, random parity and randomly skipped key slots are mixed with directed cases. Garbage is driven on every input in the idle clocks between strobes, so the parity-based hold and the clearing of the working register can be told apart at the outputs.

// File: rtl/keycap_pkg.sv
package keycap_pkg;

    // Action taken at a strobed slot
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,  // ordinary slot or idle
        ACT_CLEAR  = 2'd1,  // end of cycle, parity does not qualify
        ACT_COMMIT = 2'd2   // end of cycle, parity qualifies
    } slot_act_e;

    // True when a slot number falls inside the key window
    function automatic logic in_window(input int unsigned slot,
                                       input int unsigned first,
                                       input int unsigned count);
        return (slot >= first) && (slot < first + count);
    endfunction

endpackage

// File: rtl/keycap_slot_decode.sv
module keycap_slot_decode
    import keycap_pkg::*;
#(
    parameter int          SLOT_W        = 6,
    parameter int          FIRST_SLOT    = 8,
    parameter int          NUM_KEYS      = 49,
    parameter logic        COMMIT_PARITY = 1'b0
) (
    input  logic                slot_en,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic                sync_n,
    input  logic                scan_par,
    input  logic                key_n,
    output logic [NUM_KEYS-1:0] wr_sel,
    output logic                wr_val,
    output slot_act_e           act
);

    logic in_win;

    // One select line per key, each comparing against its own slot number
    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_sel
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(FIRST_SLOT + g);
        always_comb begin
            wr_sel[g] = slot_en && in_win && (slot_idx == MY_SLOT);
        end
    end

    always_comb begin
        in_win = in_window(int'(slot_idx), FIRST_SLOT, NUM_KEYS);
        wr_val = ~key_n;
        act    = ACT_NONE;
        if (slot_en && !sync_n) begin
            act = (scan_par == COMMIT_PARITY) ? ACT_COMMIT : ACT_CLEAR;
        end
    end

endmodule

// File: rtl/keycap_shadow.sv
module keycap_shadow
    import keycap_pkg::*;
#(
    parameter int NUM_KEYS = 49
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] wr_sel,
    input  logic                wr_val,
    input  slot_act_e           act,
    output logic [NUM_KEYS-1:0] shadow
);

    typedef struct packed {
        logic [NUM_KEYS-1:0] bits;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (wr_sel[i]) begin
                st_d.bits[i] = wr_val;
            end
        end
        // A new cycle starts after the marker slot
        if (act != ACT_NONE) begin
            st_d.bits = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow = st_q.bits;

endmodule

// File: rtl/keycap_publish.sv
module keycap_publish
    import keycap_pkg::*;
#(
    parameter int NUM_KEYS   = 49,
    parameter int LOWER_KEYS = 24,
    localparam int UPPER_KEYS = NUM_KEYS - LOWER_KEYS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  slot_act_e             act,
    input  logic [NUM_KEYS-1:0]   shadow,
    output logic [NUM_KEYS-1:0]   keys,
    output logic [LOWER_KEYS-1:0] keys_lo,
    output logic [UPPER_KEYS-1:0] keys_hi,
    output logic                  valid
);

    typedef struct packed {
        logic [NUM_KEYS-1:0] keys;
        logic                valid;
    } pub_t;

    pub_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (act == ACT_COMMIT) begin
            st_d.keys  = shadow;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign keys    = st_q.keys;
    assign keys_lo = st_q.keys[LOWER_KEYS-1:0];
    assign keys_hi = st_q.keys[NUM_KEYS-1:LOWER_KEYS];
    assign valid   = st_q.valid;

endmodule

// File: rtl/keyscan_capture.sv
module keyscan_capture
    import keycap_pkg::*;
#(
    parameter int   SLOT_W        = 6,
    parameter int   FIRST_SLOT    = 8,
    parameter int   NUM_KEYS      = 49,
    parameter int   LOWER_KEYS    = 24,
    parameter logic COMMIT_PARITY = 1'b0,
    localparam int  UPPER_KEYS    = NUM_KEYS - LOWER_KEYS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slot_en,
    input  logic [SLOT_W-1:0]     slot_idx,
    input  logic                  sync_n,
    input  logic                  scan_par,
    input  logic                  key_n,
    output logic [NUM_KEYS-1:0]   keys,
    output logic [LOWER_KEYS-1:0] keys_lo,
    output logic [UPPER_KEYS-1:0] keys_hi,
    output logic                  keys_valid
);

    logic [NUM_KEYS-1:0] wr_sel;
    logic                wr_val;
    slot_act_e           act;
    logic [NUM_KEYS-1:0] shadow_q;

    keycap_slot_decode #(
        .SLOT_W       (SLOT_W),
        .FIRST_SLOT   (FIRST_SLOT),
        .NUM_KEYS     (NUM_KEYS),
        .COMMIT_PARITY(COMMIT_PARITY)
    ) u_decode (
        .slot_en (slot_en),
        .slot_idx(slot_idx),
        .sync_n  (sync_n),
        .scan_par(scan_par),
        .key_n   (key_n),
        .wr_sel  (wr_sel),
        .wr_val  (wr_val),
        .act     (act)
    );

    keycap_shadow #(
        .NUM_KEYS(NUM_KEYS)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_sel(wr_sel),
        .wr_val(wr_val),
        .act   (act),
        .shadow(shadow_q)
    );

    keycap_publish #(
        .NUM_KEYS  (NUM_KEYS),
        .LOWER_KEYS(LOWER_KEYS)
    ) u_publish (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .shadow (shadow_q),
        .keys   (keys),
        .keys_lo(keys_lo),
        .keys_hi(keys_hi),
        .valid  (keys_valid)
    );

endmodule

// File: rtl/keyscan_capture_chk.sv
module keyscan_capture_chk #(
    parameter int   NUM_KEYS      = 49,
    parameter logic COMMIT_PARITY = 1'b0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                slot_en,
    input logic                sync_n,
    input logic                scan_par,
    input logic [NUM_KEYS-1:0] keys,
    input logic                keys_valid,
    input logic [NUM_KEYS-1:0] shadow_q
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic commit_req;
    assign commit_req = slot_en && !sync_n && (scan_par == COMMIT_PARITY);

    AST_VALID_MATCHES_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (keys_valid == $past(commit_req))); // R5

    AST_ODD_CYCLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && !sync_n && scan_par != COMMIT_PARITY) |=> !keys_valid); // R4

    AST_KEYS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !keys_valid) |-> $stable(keys)); // R8

    AST_COMMIT_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && keys_valid) |-> (keys == $past(shadow_q))); // R2

    AST_SHADOW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && !sync_n) |=> (shadow_q == '0)); // R6

endmodule

bind keyscan_capture keyscan_capture_chk #(
    .NUM_KEYS     (NUM_KEYS),
    .COMMIT_PARITY(COMMIT_PARITY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .sync_n    (sync_n),
    .scan_par  (scan_par),
    .keys      (keys),
    .keys_valid(keys_valid),
    .shadow_q  (shadow_q)
);

// File: tb/keyscan_capture_bench.sv
module keyscan_capture_bench;

    localparam int NK = 49;
    localparam int NL = 24;
    localparam int NU = NK - NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_en = 1'b0;
    logic [5:0]    slot_idx = '0;
    logic          sync_n = 1'b1;
    logic          scan_par = 1'b0;
    logic          key_n = 1'b1;
    logic [NK-1:0] keys;
    logic [NL-1:0] keys_lo;
    logic [NU-1:0] keys_hi;
    logic          keys_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [NK-1:0] model = '0;

    always #10 clk = ~clk;

    keyscan_capture u_keyscan_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .slot_idx  (slot_idx),
        .sync_n    (sync_n),
        .scan_par  (scan_par),
        .key_n     (key_n),
        .keys      (keys),
        .keys_lo   (keys_lo),
        .keys_hi   (keys_hi),
        .keys_valid(keys_valid)
    );

    function automatic logic [NK-1:0] rand_vec();
        return NK'({$urandom, $urandom});
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full scan cycle. pat: pressed keys; skip: key slots not strobed;
    // noise: drive key_n low on out-of-window slots.
    task automatic scan(input logic [NK-1:0] pat, input logic [NK-1:0] skip,
                        input logic par, input logic noise);
        logic [NK-1:0] exp_keys;
        logic          exp_valid;
        exp_valid = (par == 1'b0);
        exp_keys  = exp_valid ? (pat & ~skip) : model;
        for (int s = 0; s < 64; s++) begin
            logic is_key;
            is_key = (s >= 8) && (s <= 56);
            if (is_key && skip[s-8]) continue;
            @(negedge clk);
            slot_en  = 1'b1;
            slot_idx = 6'(s);
            sync_n   = (s != 63);
            scan_par = par;
            key_n    = is_key ? ~pat[s-8] : (noise ? 1'b0 : 1'($urandom));
            @(negedge clk);
            // idle clock with garbage on every sampled input (R9)
            slot_en  = 1'b0;
            slot_idx = 6'($urandom);
            sync_n   = 1'($urandom);
            scan_par = 1'($urandom);
            key_n    = 1'($urandom);
            if (s == 63) begin
                model = exp_keys;
                check("R4 R5 valid after marker", 64'(keys_valid), 64'(exp_valid));
                check("R2 R3 R6 keys", 64'(keys), 64'(exp_keys));
                check("R7 lower half", 64'(keys_lo), 64'(exp_keys[NL-1:0]));
                check("R7 upper half", 64'(keys_hi), 64'(exp_keys[NK-1:NL]));
                @(negedge clk);
                check("R5 valid one clock", 64'(keys_valid), 64'd0);
                check("R8 R9 keys held", 64'(keys), 64'(exp_keys));
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [NK-1:0] p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 keys after reset", 64'(keys), 64'd0);
        check("R1 valid after reset", 64'(keys_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lower after reset", 64'(keys_lo), 64'd0);
        check("R1 upper after reset", 64'(keys_hi), 64'd0);

        scan('1, '0, 1'b0, 1'b0);                     // all pressed
        scan('0, '0, 1'b0, 1'b1);                     // none pressed, noise outside window (R3)
        scan(NK'(1), '0, 1'b0, 1'b1);                 // key 1 at slot 8
        scan(NK'(1) << (NK-1), '0, 1'b0, 1'b1);       // key 49 at slot 56
        scan(NK'(3) << (NL-1), '0, 1'b0, 1'b0);       // keys 24 and 25 (R7)
        p = rand_vec();
        scan(p, '0, 1'b0, 1'b0);
        scan(~p, '0, 1'b1, 1'b0);                     // odd parity: hold (R4)
        scan('1, '0, 1'b1, 1'b0);                     // fill shadow, no commit
        scan('1, {(NK+1)/2{2'b01}} >> 1, 1'b0, 1'b0); // skipped slots read released (R6)

        for (int i = 0; i < 24; i++) begin
            logic [NK-1:0] sk;
            sk = ($urandom % 3 == 0) ? rand_vec() : '0;
            scan(rand_vec(), sk, 1'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule